// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block sits beside the datapath of a small 16-bit processor and handles interrupt entry and return. It holds one request flag for each of sixteen sources: a reset source, a non-maskable source and fourteen maskable sources. When the processor reports an instruction boundary and some request is eligible, the sequencer saves the program counter and then the status word on the stack through a word-wide memory port. It then picks the highest-priority eligible request and fetches that source's handler address from a vector table at the top of memory. Finally it hands the processor a new program counter, a cleared status word and the lowered stack pointer in one load strobe.

The return path undoes this. On a return request the sequencer reads the status word first and the program counter second, then hands both back along with the raised stack pointer. Maskable sources need the global enable bit of the status word and their own enable bit. The reset and non-maskable sources ignore both. Some maskable sources share a vector with other events. Their flags are left set for the handler software to inspect and clear.

Top module: `irq_entry_seq`

## Requirements
- R1: Source index j (0..15) has vector word address 0xFFE0 + 2*j. Index 15 is the reset source, index 14 is the non-maskable source, and index j < 14 is maskable source j. When several requests are eligible, the highest index wins, and pc_out carries the word read from the winner's vector address.
- R2: A maskable flag j is eligible only when status bit 3 (global enable) of sr_in and irq_en[j] are both 1. A flag that is set while it is not eligible stays set and is taken at a later instruction boundary once it becomes eligible.
- R3: The reset and non-maskable flags are eligible regardless of status bit 3 and of irq_en.
- R4: An entry starts at the rising edge that samples instr_done=1 in the idle state with an eligible request. The sequencer writes pc_in to address sp_in-2 and then sr_in to sp_in-4. cpu_load is then high for one cycle, beginning 6 rising edges after the sampling edge (counting that edge), with sr_out=0 and sp_out=sp_in-4.
- R5: On entry, the winner's flag is cleared if the source is single-source. Reset, the non-maskable source and maskable sources whose SHARED_MASK bit is 0 are single-source. By default maskable sources 0 and 3 share a vector. Their flags stay set, and every other flag is left as it was.
- R6: If any of the low-power bits 7:4 of sr_in is 1 when entry starts, clk_start pulses high for one cycle before the first stack write. The entry then takes one cycle longer: cpu_load begins 7 edges after the sampling edge.
- R7: A return starts at the rising edge that samples ret_req=1 in the idle state. The sequencer reads the status word from sp_in and then the program counter from sp_in+2. cpu_load begins 4 edges after the sampling edge, with sr_out and pc_out holding those words and sp_out=sp_in+4. If ret_req and an entry condition are present in the same cycle, the return goes first.
- R8: sw_clr[j]=1 clears flag j only while busy is 0. A clear while a sequence runs has no effect. If irq_set[j] and sw_clr[j] are 1 in the same cycle, the flag ends up set.
- R9: No entry starts without instr_done. busy is 1 for the whole of every entry or return sequence.
- R10: While rst is high and after it falls, busy, cpu_load, clk_start, mem_we and mem_re are 0 and every flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set | input | 16 | One-cycle request pulses; bit 15 reset, bit 14 non-maskable, bits 13:0 maskable |
| irq_en | input | 14 | Per-source enables of the maskable sources |
| sw_clr | input | 16 | Software flag clear, honoured only while idle |
| flags_out | output | 16 | Current request flags |
| instr_done | input | 1 | Processor is at an instruction boundary |
| ret_req | input | 1 | Processor executes return-from-interrupt |
| pc_in | input | 16 | Processor program counter |
| sr_in | input | 16 | Processor status word (bit 3 global enable, bits 7:4 low-power) |
| sp_in | input | 16 | Processor stack pointer |
| clk_start | output | 1 | Request to restart the processor clock |
| busy | output | 1 | A sequence is in progress |
| mem_addr | output | 16 | Word memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_re | output | 1 | Memory read strobe, data returned one cycle later |
| mem_rdata | input | 16 | Memory read data |
| cpu_load | output | 1 | One-cycle strobe to load pc_out, sr_out and sp_out |
| pc_out | output | 16 | New program counter |
| sr_out | output | 16 | New status word |
| sp_out | output | 16 | New stack pointer |

## Verification
The bench goes after priority collisions: the reset source against the non-maskable source, and the non-maskable source against a disabled maskable one. A wrong encoder there would jump to the lower vector or discard the losing flag. It tests shared-vector sources, where a design that clears every winner would lose the event the handler must find. It also tests requests made while the global enable is off, which a flawed design would drop or take early. Software clears are issued in the middle of an entry, and a set and a clear are issued in the same cycle; a wrong design would lose a live request in either case. Finally the bench presents a return and a new entry together, and enters from low-power mode, checking that the stack order and latencies stay exact.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE,
    ST_PUSH_PC,
    ST_PUSH_SR,
    ST_SELECT,
    ST_VEC_RD,
    ST_VEC_LOAD,
    ST_POP_SR,
    ST_POP_PC,
    ST_POP_END
  } seq_state_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] hw_clr_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic         sw_clr_en_i,
  output logic [N-1:0] flags_o
);

  logic [N-1:0] flags_q;
  logic [N-1:0] clr_mask;
  logic [N-1:0] keep;

  assign clr_mask = hw_clr_i | (sw_clr_i & {N{sw_clr_en_i}});
  assign keep     = flags_q & ~clr_mask;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= keep | set_i;
  end

  assign flags_o = flags_q;

  // R5, R8: a flag that nothing clears stays set
  a_r5_flags_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(keep)) == $past(keep)));

  // R8: a new request wins over a clear in the same cycle
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_q & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                DW          = 16,
  parameter int                N_MASK      = 14,
  parameter logic [DW-1:0]     VEC_BASE    = 16'hFFE0,
  parameter int                GIE_BIT     = 3,
  parameter int                LPM_LSB     = 4,
  parameter int                LPM_W       = 4,
  parameter logic [N_MASK-1:0] SHARED_MASK = 14'h0009
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MASK+1:0] irq_set,
  input  logic [N_MASK-1:0] irq_en,
  input  logic [N_MASK+1:0] sw_clr,
  output logic [N_MASK+1:0] flags_out,
  input  logic              instr_done,
  input  logic              ret_req,
  input  logic [DW-1:0]     pc_in,
  input  logic [DW-1:0]     sr_in,
  input  logic [DW-1:0]     sp_in,
  output logic              clk_start,
  output logic              busy,
  output logic [DW-1:0]     mem_addr,
  output logic              mem_we,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_re,
  input  logic [DW-1:0]     mem_rdata,
  output logic              cpu_load,
  output logic [DW-1:0]     pc_out,
  output logic [DW-1:0]     sr_out,
  output logic [DW-1:0]     sp_out
);

  localparam int N_SRC   = N_MASK + 2;
  localparam int IDX_W   = $clog2(N_SRC);
  localparam int IDX_NMI = N_MASK;
  localparam int IDX_RST = N_MASK + 1;
  localparam logic [DW-1:0] WORD = DW'(2);

  seq_state_e        state;
  logic [DW-1:0]     pc_cap, sr_cap, sp_cap, sr_pop;
  logic [N_MASK-1:0] en_cap, en_now;
  logic              gie_now;
  logic [N_SRC-1:0]  flags, elig, hw_clr, single_src;
  logic              pick_valid;
  logic [IDX_W-1:0]  pick_idx;
  logic [DW-1:0]     vec_addr;
  logic              start_ok, take_ret, take_irq, lpm_on;

  irq_flag_bank #(.N(N_SRC)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_i      (irq_set),
    .hw_clr_i   (hw_clr),
    .sw_clr_i   (sw_clr),
    .sw_clr_en_i(state == ST_IDLE),
    .flags_o    (flags)
  );

  assign flags_out = flags;

  // enables seen live while idle, frozen once a sequence starts
  assign gie_now = (state == ST_IDLE) ? sr_in[GIE_BIT] : sr_cap[GIE_BIT];
  assign en_now  = (state == ST_IDLE) ? irq_en : en_cap;

  for (genvar g = 0; g < N_MASK; g++) begin : g_mask_elig
    assign elig[g] = flags[g] & en_now[g] & gie_now;
  end
  assign elig[IDX_NMI] = flags[IDX_NMI];
  assign elig[IDX_RST] = flags[IDX_RST];

  irq_prio_pick #(.N(N_SRC), .IW(IDX_W)) u_pick (
    .req_i  (elig),
    .valid_o(pick_valid),
    .idx_o  (pick_idx)
  );

  assign single_src = {2'b11, ~SHARED_MASK};
  assign hw_clr     = (state == ST_SELECT && pick_valid)
                      ? (single_src & (N_SRC'(1) << pick_idx)) : '0;
  assign vec_addr   = VEC_BASE + DW'({pick_idx, 1'b0});

  assign lpm_on   = |sr_in[LPM_LSB +: LPM_W];
  assign start_ok = (state == ST_IDLE) && !cpu_load;
  assign take_ret = start_ok && ret_req;
  assign take_irq = start_ok && !ret_req && instr_done && pick_valid;
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      clk_start <= 1'b0;
      cpu_load  <= 1'b0;
      pc_out    <= '0;
      sr_out    <= '0;
      sp_out    <= '0;
      pc_cap    <= '0;
      sr_cap    <= '0;
      sp_cap    <= '0;
      sr_pop    <= '0;
      en_cap    <= '0;
    end else begin
      cpu_load  <= 1'b0;
      clk_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take_ret) begin
            sp_cap   <= sp_in;
            mem_re   <= 1'b1;
            mem_addr <= sp_in;
            state    <= ST_POP_SR;
          end else if (take_irq) begin
            pc_cap <= pc_in;
            sr_cap <= sr_in;
            sp_cap <= sp_in;
            en_cap <= irq_en;
            if (lpm_on) begin
              clk_start <= 1'b1;
              state     <= ST_WAKE;
            end else begin
              mem_we    <= 1'b1;
              mem_addr  <= sp_in - WORD;
              mem_wdata <= pc_in;
              state     <= ST_PUSH_PC;
            end
          end
        end
        ST_WAKE: begin
          mem_we    <= 1'b1;
          mem_addr  <= sp_cap - WORD;
          mem_wdata <= pc_cap;
          state     <= ST_PUSH_PC;
        end
        ST_PUSH_PC: begin
          mem_addr  <= sp_cap - WORD - WORD;
          mem_wdata <= sr_cap;
          state     <= ST_PUSH_SR;
        end
        ST_PUSH_SR: begin
          mem_we <= 1'b0;
          state  <= ST_SELECT;
        end
        ST_SELECT: begin
          mem_re   <= 1'b1;
          mem_addr <= vec_addr;
          state    <= ST_VEC_RD;
        end
        ST_VEC_RD: begin
          mem_re <= 1'b0;
          state  <= ST_VEC_LOAD;
        end
        ST_VEC_LOAD: begin
          pc_out   <= mem_rdata;
          sr_out   <= '0;
          sp_out   <= sp_cap - WORD - WORD;
          cpu_load <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_POP_SR: begin
          mem_addr <= sp_cap + WORD;
          state    <= ST_POP_PC;
        end
        ST_POP_PC: begin
          mem_re <= 1'b0;
          sr_pop <= mem_rdata;
          state  <= ST_POP_END;
        end
        ST_POP_END: begin
          pc_out   <= mem_rdata;
          sr_out   <= sr_pop;
          sp_out   <= sp_cap + WORD + WORD;
          cpu_load <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: the chosen index is the highest eligible one
  a_r1_pick_top: assert property (@(posedge clk) disable iff (rst)
    pick_valid |-> ((elig >> pick_idx) == N_SRC'(1)));

  // R1: vector fetch stays inside the table and word aligned
  a_r1_vec_window: assert property (@(posedge clk) disable iff (rst)
    (mem_re && state == ST_VEC_RD) |-> (mem_addr >= VEC_BASE && !mem_addr[0]));

  // R4: consecutive stack writes step down by one word
  a_r4_push_step: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - WORD));

  // R6: the clock restart comes right before the first push
  a_r6_wake_first: assert property (@(posedge clk) disable iff (rst)
    clk_start |=> (mem_we && !clk_start));

  // R9: without a boundary or return, the idle state holds
  a_r9_no_start: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !instr_done && !ret_req) |=> (state == ST_IDLE));

  // R2: with global enable off and no unmaskable flag, nothing starts
  a_r2_gie_gate: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !ret_req && !sr_in[GIE_BIT]
     && flags[IDX_RST] == 1'b0 && flags[IDX_NMI] == 1'b0) |=> (state == ST_IDLE));

endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_set = '0;
  logic [13:0] irq_en = '0;
  logic [15:0] sw_clr = '0;
  logic [15:0] flags_out;
  logic        instr_done = 1'b0;
  logic        ret_req = 1'b0;
  logic [15:0] cpu_pc = '0, cpu_sr = '0, cpu_sp = '0;
  logic        clk_start, busy, mem_we, mem_re, cpu_load;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_out, sr_out, sp_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] ld_pc, ld_sr, ld_sp;
  logic [15:0] smem [0:255];

  always #4 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst(rst), .irq_set(irq_set), .irq_en(irq_en), .sw_clr(sw_clr),
    .flags_out(flags_out), .instr_done(instr_done), .ret_req(ret_req),
    .pc_in(cpu_pc), .sr_in(cpu_sr), .sp_in(cpu_sp), .clk_start(clk_start),
    .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .cpu_load(cpu_load),
    .pc_out(pc_out), .sr_out(sr_out), .sp_out(sp_out)
  );

  function automatic logic [15:0] hnd(input logic [3:0] i);
    return 16'hA000 | {8'h00, i, 4'h0};
  endfunction

  always @(posedge clk) begin
    if (mem_we) smem[mem_addr[8:1]] <= mem_wdata;
    if (mem_re) mem_rdata <= (mem_addr >= 16'hFFE0) ? hnd(mem_addr[4:1])
                                                   : smem[mem_addr[8:1]];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_load(output int lat, output int wake_at);
    lat = 0;
    wake_at = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      instr_done = 1'b0;
      ret_req = 1'b0;
      if (clk_start && wake_at == 0) wake_at = k;
      if (cpu_load) begin
        lat = k;
        ld_pc = pc_out; ld_sr = sr_out; ld_sp = sp_out;
        cpu_pc = pc_out; cpu_sr = sr_out; cpu_sp = sp_out;
        break;
      end
    end
  endtask

  task automatic try_entry(output int lat, output int wake_at);
    @(negedge clk);
    instr_done = 1'b1;
    wait_load(lat, wake_at);
  endtask

  task automatic do_ret(output int lat);
    int w;
    @(negedge clk);
    ret_req = 1'b1;
    wait_load(lat, w);
  endtask

  task automatic pulse_set(input logic [15:0] m);
    @(negedge clk); irq_set = m;
    @(negedge clk); irq_set = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); sw_clr = 16'hFFFF;
    @(negedge clk); sw_clr = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // fields: set[36:21] en[20:7] gie[6] lpm[5] winner[4:0] (31 = no entry)
  localparam int NV = 9;
  localparam logic [36:0] TV [NV] = '{
    {16'h0020, 14'h0020, 1'b1, 1'b0, 5'd5},
    {16'h0220, 14'h0220, 1'b1, 1'b0, 5'd9},
    {16'h0200, 14'h0000, 1'b1, 1'b0, 5'd31},
    {16'h0200, 14'h0200, 1'b0, 1'b0, 5'd31},
    {16'h6000, 14'h2000, 1'b0, 1'b0, 5'd14},
    {16'hC000, 14'h0000, 1'b0, 1'b0, 5'd15},
    {16'h0001, 14'h0001, 1'b1, 1'b1, 5'd0},
    {16'h0008, 14'h0008, 1'b1, 1'b0, 5'd3},
    {16'h3000, 14'h3FFF, 1'b1, 1'b0, 5'd13}
  };

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat, wk;
    logic [15:0] set_m, old_pc, old_sr, exp_fl;
    logic [4:0] win;

    repeat (3) @(negedge clk);
    check("R10 busy in reset", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 outputs idle", {busy, cpu_load, clk_start, mem_we, mem_re}, 0);
    check("R10 flags clear", flags_out, 0);

    for (int v = 0; v < NV; v++) begin
      set_m = TV[v][36:21];
      win   = TV[v][4:0];
      clear_all();
      old_pc = 16'h4000 + 16'(v * 6);
      old_sr = 16'h0100 | (TV[v][6] ? 16'h0008 : 16'h0) | (TV[v][5] ? 16'h0010 : 16'h0);
      cpu_pc = old_pc; cpu_sr = old_sr; cpu_sp = 16'h0100;
      irq_en = TV[v][20:7];
      pulse_set(set_m);
      try_entry(lat, wk);
      if (win == 5'd31) begin
        check("R2 not taken", lat, 0);
        check("R2 flags kept pending", flags_out, set_m);
      end else begin
        check("R4/R6 entry latency", lat, TV[v][5] ? 7 : 6);
        if (TV[v][5]) check("R6 wake before push", wk, 1);
        check("R1 handler pc", ld_pc, hnd(win[3:0]));
        check("R4 sr cleared", ld_sr, 0);
        check("R4 sp lowered", ld_sp, 16'h00FC);
        check("R4 pc pushed", smem[8'h7F], old_pc);
        check("R4 sr pushed", smem[8'h7E], old_sr);
        exp_fl = set_m;
        if (!(win == 5'd0 || win == 5'd3)) exp_fl[win[3:0]] = 1'b0;
        check("R5 flags after entry", flags_out, exp_fl);
        do_ret(lat);
        check("R7 return latency", lat, 4);
        check("R7 pc restored", ld_pc, old_pc);
        check("R7 sr restored", ld_sr, old_sr);
        check("R7 sp restored", ld_sp, 16'h0100);
      end
    end

    // R2: pending request taken once global enable is on
    clear_all();
    irq_en = 14'h0080; cpu_sr = 16'h0000; cpu_sp = 16'h0100; cpu_pc = 16'h5000;
    pulse_set(16'h0080);
    try_entry(lat, wk);
    check("R2 blocked while disabled", lat, 0);
    cpu_sr = 16'h0008;
    try_entry(lat, wk);
    check("R2 taken after enable", lat, 6);
    check("R2 handler", ld_pc, hnd(4'd7));

    // R9: no boundary, no entry
    clear_all();
    cpu_sr = 16'h0008; cpu_sp = 16'h0100;
    pulse_set(16'h0080);
    wk = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (busy || cpu_load) wk = 1;
    end
    check("R9 stays idle without instr_done", wk, 0);

    // R8: software clear ignored mid-sequence
    clear_all();
    irq_en = 14'h3FFF; cpu_sr = 16'h0008; cpu_sp = 16'h0100;
    pulse_set(16'h0024);
    @(negedge clk); instr_done = 1'b1;
    @(negedge clk); instr_done = 1'b0; sw_clr = 16'h0004;
    check("R9 busy during entry", busy, 1);
    @(negedge clk); sw_clr = '0;
    wait_load(lat, wk);
    check("R8 entry unaffected", lat, 4);
    check("R8 clear ignored while busy", flags_out, 16'h0004);
    clear_all();
    check("R8 clear works when idle", flags_out, 0);
    @(negedge clk); irq_set = 16'h0010; sw_clr = 16'h0010;
    @(negedge clk); irq_set = '0; sw_clr = '0;
    check("R8 set wins over clear", flags_out, 16'h0010);

    // R7/R3: return before a same-cycle entry, then non-maskable entry
    clear_all();
    irq_en = 14'h0020; cpu_pc = 16'h1234; cpu_sr = 16'h0108; cpu_sp = 16'h0100;
    pulse_set(16'h0020);
    try_entry(lat, wk);
    check("R4 setup entry", lat, 6);
    pulse_set(16'h4000);
    @(negedge clk); ret_req = 1'b1; instr_done = 1'b1;
    wait_load(lat, wk);
    check("R7 return wins", lat, 4);
    check("R7 pc after return", ld_pc, 16'h1234);
    check("R7 sr after return", ld_sr, 16'h0108);
    try_entry(lat, wk);
    check("R3 nmi taken after return", lat, 6);
    check("R3 nmi handler", ld_pc, hnd(4'd14));

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule